// File: doc/BRIEF.md
# Ready-Edge Triggered Serial Capture Sequencer

This block waits for an external converter to announce fresh data on an active-low ready line that is not related to the local clock. It passes that line through a two-flop synchronizer and looks for a high-to-low change. Each such change launches exactly one fixed-length read burst on an SPI-style master port: chip select goes active, a divided serial clock shifts in one word most significant bit first, chip select is released, and the captured word is presented with a one-cycle valid strobe.

Because the trigger is the falling transition and not the low level, a ready line that stays low after a burst does not start another one. A transition that arrives while a burst is running is dropped, not remembered. A controller state code outside the defined set returns to idle on the next clock.

Top module: `drdy_spi_capture`

## Requirements
- R1: While the synchronous active-low reset is sampled low at a clock edge, the outputs after that edge are: chip select high (inactive), serial clock low, busy low, valid low, and captured word all zeros.
- R2: The ready line passes two flip-flops before use; if it is first sampled low at clock edge k after being sampled high at edge k-1, busy is low after edge k and high after edge k+1.
- R3: Only a high-to-low change of the ready line starts a burst; a ready line held low after a burst has ended starts no further burst.
- R4: A falling change of the ready line that arrives while a burst runs is ignored and is not queued: no second burst follows.
- R5: Chip select becomes active (low) one clock before the first serial clock half-period; the first serial clock half-period is low.
- R6: The serial clock runs at half the block clock for 2 x 48 = 96 block cycles (low half first); the input bit is taken on each rising serial clock edge, 48 bits, first bit into the most significant position.
- R7: Chip select stays low for exactly 98 consecutive block cycles per complete burst (one lead cycle, 96 shift cycles, one release cycle), and busy is high in exactly those cycles.
- R8: In the first cycle after chip select returns high, valid is high for one cycle together with the captured word; the word then holds until the next completed burst.
- R9: A controller state code outside the defined set leads to idle on the next clock edge (busy low, chip select high).
- R10: Reset is synchronous: asserting it mid-burst changes no output until the next clock edge, after which the R1 values apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ready_n_async | input | 1 | Active-low data-ready line from the external converter, asynchronous |
| spi_miso | input | 1 | Serial data from the slave |
| spi_sclk | output | 1 | Serial clock, block clock divided by two during a burst |
| spi_cs_n | output | 1 | Chip select, active low |
| word_out | output | 48 | Last captured word |
| word_valid | output | 1 | One-cycle strobe with a new word |
| busy | output | 1 | High while a burst is in progress |

## Verification
The hardest situation to reach from the ports is an undefined controller state code: no legal input sequence produces one. The bench forces the state register to an undefined code for part of one cycle in the middle of a burst, releases it before the clock edge, and tells its reference model to expect idle after that edge. Ready-line transitions mid-burst and a line held low past the end of a burst are produced by timed stimulus and compared cycle by cycle against the model.

// File: rtl/drdy_capture_pkg.sv
// Shared types for the ready-triggered serial capture sequencer.
// Assumes: state codes outside the listed set are treated as illegal.
package drdy_capture_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_TAIL  = 3'd3
    } seq_state_t;

endpackage

// File: rtl/ready_edge_sync.sv
// Brings the asynchronous active-low ready line into the clock domain and
// produces a one-cycle pulse on each synchronized high-to-low change.
// Assumes: SYNC_STAGES >= 2; the line idles high.
module ready_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic fall_pulse
);

    localparam int OLD_IDX = SYNC_STAGES - 1;
    localparam int NEW_IDX = SYNC_STAGES - 2;

    logic [SYNC_STAGES-1:0] chain_q;

    // Purpose: shift the raw line through the synchronizer flops (index 0 newest).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], line_n};
        end
    end

    // Purpose: older stage high and newer stage low marks a falling change.
    always_comb begin
        fall_pulse = chain_q[OLD_IDX] & ~chain_q[NEW_IDX];
    end

endmodule

// File: rtl/burst_sequencer.sv
// Single-process controller: idle, one lead cycle, 2*WORD_BITS shift cycles,
// one release cycle, then idle. Drives chip select, serial clock and the
// sample/finish strobes for the datapath.
// Assumes: start_i is a one-cycle pulse; it is ignored outside idle.
module burst_sequencer
    import drdy_capture_pkg::*;
#(
    parameter int WORD_BITS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic cs_n_o,
    output logic sclk_o,
    output logic sample_o,
    output logic finish_o
);

    localparam int SHIFT_CYC = 2 * WORD_BITS;
    localparam int CNT_W     = $clog2(SHIFT_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SHIFT_CYC - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: advance the burst sequence; undefined codes fall back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start_i) state_q <= ST_LEAD;
                end
                ST_LEAD: begin
                    cnt_q   <= '0;
                    state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_q   <= '0;
                        state_q <= ST_TAIL;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_TAIL: begin
                    cnt_q   <= '0;
                    state_q <= ST_IDLE;
                end
                default: begin
                    cnt_q   <= '0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Purpose: decode port-level outputs and datapath strobes from the state.
    always_comb begin
        busy_o   = (state_q != ST_IDLE);
        cs_n_o   = (state_q == ST_IDLE);
        sclk_o   = (state_q == ST_SHIFT) && cnt_q[0];
        sample_o = (state_q == ST_SHIFT) && !cnt_q[0];
        finish_o = (state_q == ST_TAIL);
    end

    // R2: busy only rises after a synchronized trigger pulse.
    a_r2_busy_from_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R4: a trigger during shifting must not restart the sequence.
    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && start_i) |=> (state_q != ST_LEAD));

    // R9: any undefined code is followed by idle.
    a_r9_illegal_recovers: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q inside {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TAIL}) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/capture_shifter.sv
// Collects serial input bits, most significant first, and presents the
// completed word with a one-cycle valid strobe.
// Assumes: sample_i pulses exactly WORD_BITS times before finish_i.
module capture_shifter #(
    parameter int WORD_BITS = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 miso_i,
    input  logic                 sample_i,
    input  logic                 finish_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 valid_o
);

    logic [WORD_BITS-1:0] acc_q;

    // Purpose: shift in one bit per sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (sample_i) begin
            acc_q <= {acc_q[WORD_BITS-2:0], miso_i};
        end
    end

    // Purpose: publish the word and pulse valid when the burst finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= finish_i;
            if (finish_i) word_o <= acc_q;
        end
    end

    // R8: valid never lasts longer than one cycle.
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: the word changes only with a valid strobe.
    a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(word_o) || $past(!rst_n));

endmodule

// File: rtl/drdy_spi_capture.sv
// Top level: ready-line edge synchronizer, burst controller and capture
// shifter. One burst per synchronized falling change of the ready line.
// Assumes: the ready line stays at each level for at least two clocks.
module drdy_spi_capture #(
    parameter int WORD_BITS   = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ready_n_async,
    input  logic                 spi_miso,
    output logic                 spi_sclk,
    output logic                 spi_cs_n,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_valid,
    output logic                 busy
);

    localparam int BURST_LEN = 2 * WORD_BITS + 2;
    localparam int MON_W     = $clog2(BURST_LEN + 2);

    logic trig;
    logic sample_en;
    logic finish;

    ready_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_n     (ready_n_async),
        .fall_pulse (trig)
    );

    burst_sequencer #(.WORD_BITS(WORD_BITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (trig),
        .busy_o   (busy),
        .cs_n_o   (spi_cs_n),
        .sclk_o   (spi_sclk),
        .sample_o (sample_en),
        .finish_o (finish)
    );

    capture_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .miso_i   (spi_miso),
        .sample_i (sample_en),
        .finish_i (finish),
        .word_o   (word_out),
        .valid_o  (word_valid)
    );

    // Assertion support: count serial clock rises and chip-select low cycles
    // within the current burst.
    logic             cs_q;
    logic             sclk_q;
    logic [MON_W-1:0] rise_cnt;
    logic [MON_W-1:0] low_cnt;

    // Purpose: track burst length and bit count as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q     <= 1'b1;
            sclk_q   <= 1'b0;
            rise_cnt <= '0;
            low_cnt  <= '0;
        end else begin
            cs_q   <= spi_cs_n;
            sclk_q <= spi_sclk;
            if (cs_q && !spi_cs_n) begin
                rise_cnt <= '0;
                low_cnt  <= MON_W'(1);
            end else begin
                if (!spi_cs_n) low_cnt <= low_cnt + 1'b1;
                if (spi_sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // R6: a completed burst carries exactly WORD_BITS rising serial clocks.
    a_r6_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (rise_cnt == MON_W'(WORD_BITS)));

    // R7: chip select was low for the full burst length.
    a_r7_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (low_cnt == MON_W'(BURST_LEN)));

    // R5: the serial clock is low while chip select first goes active.
    a_r5_cs_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q && !spi_cs_n) |-> !spi_sclk);

    // R8: valid appears only after the burst, with the port idle.
    a_r8_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (spi_cs_n && !busy));

endmodule

// File: tb/drdy_spi_capture_test.sv
`timescale 1ns/1ps
module drdy_spi_capture_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rdy_n = 1'b1;
    logic        miso = 1'b0;
    logic        sclk, cs_n, wvalid, busy;
    logic [47:0] word;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    drdy_spi_capture uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ready_n_async (rdy_n),
        .spi_miso      (miso),
        .spi_sclk      (sclk),
        .spi_cs_n      (cs_n),
        .word_out      (word),
        .word_valid    (wvalid),
        .busy          (busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: phase -1 idle, 0 lead, 1..96 shift, 97 release.
    int          ph = -1;
    logic [47:0] m_acc = '0, m_word = '0;
    logic        m_valid = 1'b0;
    logic        h_new = 1'b1, h_old = 1'b1;
    bit          inject = 1'b0;
    bit          started = 1'b0;

    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            ph = -1; m_acc = '0; m_word = '0; m_valid = 1'b0;
            h_new = 1'b1; h_old = 1'b1;
        end else begin
            m_valid = 1'b0;
            if (inject) begin
                ph = -1;
                inject = 1'b0;
            end else if (ph == -1) begin
                if (h_old && !h_new) ph = 0;
            end else if (ph == 97) begin
                ph = -1; m_valid = 1'b1; m_word = m_acc;
            end else begin
                if (ph >= 1 && ph <= 96 && (ph % 2) == 1) m_acc = {m_acc[46:0], miso};
                ph++;
            end
            h_old = h_new;
            h_new = rdy_n;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (started) begin
            chk(busy == (ph != -1), "R7 busy", 48'(busy), 48'(ph != -1));
            chk(cs_n == (ph == -1), "R5 cs_n", 48'(cs_n), 48'(ph == -1));
            chk(sclk == (ph >= 1 && ph <= 96 && (ph % 2) == 0), "R6 sclk",
                48'(sclk), 48'(ph >= 1 && ph <= 96 && (ph % 2) == 0));
            chk(wvalid == m_valid, "R8 valid", 48'(wvalid), 48'(m_valid));
            chk(word == m_word, "R6 word", word, m_word);
        end
    end

    // Slave: presents pattern bits while sclk is low, or random bits.
    bit          slave_pat = 1'b0;
    logic [47:0] pat = 48'hA5C3_0F1E_9B27;
    int          bidx = 0;
    always @(negedge clk) begin
        if (cs_n) bidx = 0;
        else if (sclk) bidx++;
        if (!slave_pat) miso = 1'($urandom);
        else if (bidx < 48) miso = pat[47 - bidx];
    end

    task automatic pulse_ready(input int low_cycles);
        @(negedge clk) rdy_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        rdy_n = 1'b1;
    endtask

    task automatic wait_valid();
        int guard = 0;
        while (!wvalid && guard < 300) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        int n;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(busy == 1'b0 && cs_n == 1'b1 && sclk == 1'b0 && wvalid == 1'b0, "R1 reset outputs",
            48'({busy, cs_n, sclk, wvalid}), 48'b0100);
        chk(word == 48'h0, "R1 reset word", word, 48'h0);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2/R5/R6/R7/R8/R3: patterned burst with ready held low afterwards
        slave_pat = 1'b1;
        rdy_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R2 busy after first edge", 48'(busy), 48'h0);
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after second edge", 48'(busy), 48'h1);
        chk(cs_n == 1'b0 && sclk == 1'b0, "R5 lead cycle", 48'({cs_n, sclk}), 48'h0);
        @(negedge clk);
        chk(sclk == 1'b0, "R5 first half low", 48'(sclk), 48'h0);
        n = 1;
        while (!wvalid && n < 300) begin
            if (!cs_n) n++;
            @(negedge clk);
        end
        chk(n == 98, "R7 cs low length", 48'(n), 48'd98);
        chk(wvalid == 1'b1 && word == pat, "R6 msb-first word", word, pat);
        @(negedge clk);
        chk(wvalid == 1'b0 && word == pat, "R8 single strobe, word held", 48'(wvalid), 48'h0);
        n = 0;
        repeat (150) begin
            @(negedge clk);
            if (busy) n++;
        end
        chk(n == 0, "R3 held-low line no retrigger", 48'(n), 48'h0);
        rdy_n = 1'b1;
        slave_pat = 1'b0;
        repeat (4) @(negedge clk);

        // R4: second falling change mid-burst is dropped
        pulse_ready(2);
        repeat (30) @(negedge clk);
        pulse_ready(3);
        wait_valid();
        n = 0;
        repeat (40) begin
            @(negedge clk);
            if (busy) n++;
        end
        chk(n == 0, "R4 mid-burst edge ignored", 48'(n), 48'h0);

        // R9: undefined state code mid-burst returns to idle
        pulse_ready(2);
        repeat (20) @(negedge clk);
        #1;
        force uut.u_ctrl.state_q = drdy_capture_pkg::seq_state_t'(3'b111);
        inject = 1'b1;
        #1;
        release uut.u_ctrl.state_q;
        @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1, "R9 illegal to idle", 48'({busy, cs_n}), 48'b01);
        repeat (5) @(negedge clk);
        pulse_ready(2);
        wait_valid();
        repeat (3) @(negedge clk);

        // R10: synchronous reset mid-burst
        pulse_ready(2);
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        chk(busy == 1'b1 && cs_n == 1'b0, "R10 no change before edge", 48'({busy, cs_n}), 48'b10);
        @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1 && word == 48'h0, "R10 reset at edge",
            48'({busy, cs_n}), 48'b01);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Several random bursts with varying ready widths
        for (int k = 0; k < 4; k++) begin
            pulse_ready(2 + k * 7);
            wait_valid();
            repeat (3 + k) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule